// File: doc/BRIEF.md
# Secure Local Injection Port for a 2D-Mesh Router

This block is the input port through which a processing core injects packets into a five-port mesh router. Packets of four flits (head, two bodies, tail) enter a small buffer through a ready/valid handshake. The flit at the front of the buffer is examined. When it is a head, its access-rights field is compared with a secure-mode value wired into the router from trusted hardware. Software running on the core cannot alter that value.

When the rights agree with the secure mode, the port computes the output direction by dimension-order routing (X first, then Y). It raises a request for that output and, once granted, streams the packet out in cut-through fashion: flits leave as soon as they are at the buffer front, without waiting for the tail. When the rights disagree, the port raises a one-cycle alert, discards the head and drains the rest of that packet without ever requesting an output.

The router's own coordinates are parameters. The other four router ports, the crossbar and the response to an alert lie outside this block.

Top module: `secure_local_port`

## Requirements
- R1: Out of reset, `in_ready` is 1, and `out_valid`, `out_req` and `alert` are 0.
- R2: Flit tags are 2'b01 head, 2'b10 body, 2'b11 tail and 2'b00 idle. Any flit reaching the buffer front while no packet is open and whose tag is not head is discarded. Such a flit produces no output flit, no request and no alert.
- R3: The head payload carries the destination Y in bits [3:0], the destination X in bits [7:4], the source Y in bits [11:8], the source X in bits [15:12] and the rights in bits [17:16]. Rights are 2'b01 write-only, 2'b10 read-only, 2'b11 read-and-write and 2'b00 none. The check passes only when the rights equal `secure_mode` and are not 2'b00.
- R4: For a passing head, `out_req` is raised. After `out_grant`, all flits of the packet up to and including the tail appear on `out_tag`/`out_data` in order and unchanged.
- R5: For a failing head, `alert` is high for exactly one cycle and the whole packet is discarded, with no `out_req` and no output flit.
- R6: The port code is 0 local, 1 east, 2 west, 3 north and 4 south. X is resolved first: a destination X above the router's X gives east, and below it gives west. On an equal X, a destination Y above the router's Y gives north, below gives south, and equal gives local.
- R7: Cut-through: once granted, the head is offered on the output before the rest of the packet has been accepted at the input.
- R8: When the buffer holds DEPTH flits, `in_ready` is 0.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_tag` and `out_data` hold their values.
- R10: `out_port` stays constant while a granted packet is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| secure_mode | input | 2 | Rights value allowed by trusted hardware |
| in_valid | input | 1 | Injected flit valid |
| in_ready | output | 1 | Buffer can take a flit |
| in_tag | input | 2 | Injected flit tag |
| in_data | input | DATA_W | Injected flit payload |
| out_req | output | 1 | Request for the routed output |
| out_port | output | 3 | Routed output direction |
| out_grant | input | 1 | Grant of the requested output |
| out_valid | output | 1 | Outgoing flit valid |
| out_ready | input | 1 | Downstream accepts the flit |
| out_tag | output | 2 | Outgoing flit tag |
| out_data | output | DATA_W | Outgoing flit payload |
| alert | output | 1 | One-cycle pulse on a rejected head |

## Verification
Two functions of this block can fall in the same cycle: draining a rejected packet from the buffer front, and accepting the next packet's flits at the buffer back. The bench provokes this by injecting a packet whose rights disagree with the secure mode, followed at once by a passing packet. It judges the result by three things: exactly one alert, exactly four output flits, and the first output flit equal to the second packet's head. It also stalls the output with a full buffer, to see backpressure and output holding coincide.

// File: rtl/slp_pkg.sv
package slp_pkg;
  localparam int COORD_W = 4;
  localparam int PORT_W  = 3;

  typedef enum logic [1:0] {
    TAG_IDLE = 2'b00,
    TAG_HEAD = 2'b01,
    TAG_BODY = 2'b10,
    TAG_TAIL = 2'b11
  } tag_t;

  localparam logic [PORT_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [PORT_W-1:0] PORT_EAST  = 3'd1;
  localparam logic [PORT_W-1:0] PORT_WEST  = 3'd2;
  localparam logic [PORT_W-1:0] PORT_NORTH = 3'd3;
  localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd4;

  localparam logic [1:0] RIGHTS_NONE = 2'b00;

  // header field positions
  localparam int DY_LO = 0;
  localparam int DX_LO = 4;
  localparam int RT_LO = 16;
  localparam int HDR_W = 18;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_DRAIN} ctrl_st_t;

  function automatic logic rights_ok(input logic [1:0] rights,
                                     input logic [1:0] mode);
    return (rights != RIGHTS_NONE) && (rights == mode);
  endfunction

  function automatic logic [PORT_W-1:0] xy_route(
      input logic [COORD_W-1:0] here_x, input logic [COORD_W-1:0] here_y,
      input logic [COORD_W-1:0] dst_x,  input logic [COORD_W-1:0] dst_y);
    logic [PORT_W-1:0] p;
    if (dst_x > here_x)      p = PORT_EAST;
    else if (dst_x < here_x) p = PORT_WEST;
    else if (dst_y > here_y) p = PORT_NORTH;
    else if (dst_y < here_y) p = PORT_SOUTH;
    else                     p = PORT_LOCAL;
    return p;
  endfunction
endpackage

// File: rtl/slp_fifo.sv
module slp_fifo #(
  parameter int WIDTH = 34,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_pop,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push, pop;

  assign wr_ready = (count != CNT_FULL);
  assign rd_valid = (count != '0);
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_pop && rd_valid;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  // R8: occupancy moves by one per unbalanced transfer
  a_r8_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1));
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/slp_guard.sv
module slp_guard
  import slp_pkg::*;
#(
  parameter logic [COORD_W-1:0] HERE_X = 4'd2,
  parameter logic [COORD_W-1:0] HERE_Y = 4'd2
) (
  input  logic [1:0]        rights,
  input  logic [COORD_W-1:0] dst_x,
  input  logic [COORD_W-1:0] dst_y,
  input  logic [1:0]        secure_mode,
  output logic              chk_ok,
  output logic [PORT_W-1:0] route_port
);
  assign chk_ok     = rights_ok(rights, secure_mode);
  assign route_port = xy_route(HERE_X, HERE_Y, dst_x, dst_y);

  // R6: a route never names a port outside the five defined codes
  always_comb begin
    a_r6_port_range: assert (route_port <= PORT_SOUTH);
  end
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  logic [1:0]        head_tag,
  input  logic              chk_ok,
  input  logic [PORT_W-1:0] route_port,
  input  logic              out_grant,
  input  logic              out_ready,
  output logic              pop,
  output logic              out_req,
  output logic              out_valid,
  output logic [PORT_W-1:0] out_port,
  output logic              alert
);
  ctrl_st_t          st, nxt;
  logic [PORT_W-1:0] port_q;
  logic              is_head, is_tail, reject_now, grant_now;

  assign is_head    = (head_tag == TAG_HEAD);
  assign is_tail    = (head_tag == TAG_TAIL);
  assign reject_now = (st == S_IDLE) && head_valid && is_head && !chk_ok;
  assign grant_now  = (st == S_IDLE) && out_req && out_grant;

  always_comb begin
    nxt       = st;
    pop       = 1'b0;
    out_req   = 1'b0;
    out_valid = 1'b0;
    case (st)
      S_IDLE: begin
        if (head_valid) begin
          if (!is_head) begin
            pop = 1'b1;
          end else if (chk_ok) begin
            out_req = 1'b1;
            if (out_grant) nxt = S_SEND;
          end else begin
            pop = 1'b1;
            nxt = S_DRAIN;
          end
        end
      end
      S_SEND: begin
        out_valid = head_valid;
        pop       = head_valid && out_ready;
        if (pop && is_tail) nxt = S_IDLE;
      end
      S_DRAIN: begin
        pop = head_valid;
        if (head_valid && is_tail) nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      port_q <= PORT_LOCAL;
      alert  <= 1'b0;
    end else begin
      st    <= nxt;
      alert <= reject_now;
      if (grant_now) port_q <= route_port;
    end
  end

  assign out_port = (st == S_SEND) ? port_q : route_port;

  // R5: a rejected packet never reaches the output side
  a_r5_alert_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> (!out_req && !out_valid));
  // R5: alert is a single-cycle pulse
  a_r5_alert_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    alert |=> !alert);
  // R10: direction held while the packet streams
  a_r10_port_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && nxt == S_SEND) |=> $stable(out_port));
endmodule

// File: rtl/secure_local_port.sv
module secure_local_port
  import slp_pkg::*;
#(
  parameter int                 DATA_W = 32,
  parameter int                 DEPTH  = 4,
  parameter logic [COORD_W-1:0] HERE_X = 4'd2,
  parameter logic [COORD_W-1:0] HERE_Y = 4'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        secure_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_req,
  output logic [2:0]        out_port,
  input  logic              out_grant,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_tag,
  output logic [DATA_W-1:0] out_data,
  output logic              alert
);
  localparam int ENTRY_W = DATA_W + 2;

  logic [ENTRY_W-1:0] head_entry;
  logic               head_valid, pop, chk_ok;
  logic [PORT_W-1:0]  route_port;
  logic [1:0]         head_tag;
  logic [DATA_W-1:0]  head_data;

  slp_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (in_valid),
    .wr_ready (in_ready),
    .wr_data  ({in_tag, in_data}),
    .rd_pop   (pop),
    .rd_valid (head_valid),
    .rd_data  (head_entry)
  );

  assign head_tag  = head_entry[ENTRY_W-1 -: 2];
  assign head_data = head_entry[DATA_W-1:0];

  slp_guard #(.HERE_X(HERE_X), .HERE_Y(HERE_Y)) u_guard (
    .rights      (head_data[RT_LO +: 2]),
    .dst_x       (head_data[DX_LO +: COORD_W]),
    .dst_y       (head_data[DY_LO +: COORD_W]),
    .secure_mode (secure_mode),
    .chk_ok      (chk_ok),
    .route_port  (route_port)
  );

  slp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (head_valid),
    .head_tag   (head_tag),
    .chk_ok     (chk_ok),
    .route_port (route_port),
    .out_grant  (out_grant),
    .out_ready  (out_ready),
    .pop        (pop),
    .out_req    (out_req),
    .out_valid  (out_valid),
    .out_port   (out_port),
    .alert      (alert)
  );

  assign out_tag  = head_tag;
  assign out_data = head_data;

  // R4: a request is only made for a head that passed the rights check
  a_r4_req_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> (chk_ok && head_tag == TAG_HEAD));
  // R9: offered flit holds under output backpressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_tag) && $stable(out_data)));
  // R2: a request never accompanies a discard
  a_r2_no_req_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |-> !pop);
endmodule

// File: tb/secure_local_port_test.sv
`timescale 1ns/1ps
module secure_local_port_test;
  localparam int DW = 32;
  localparam int NV = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    secure_mode = 2'b11;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_tag = 2'b00;
  logic [DW-1:0] in_data = '0;
  logic          out_req;
  logic [2:0]    out_port;
  logic          out_grant = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    out_tag;
  logic [DW-1:0] out_data;
  logic          alert;

  always #10 clk = ~clk;

  secure_local_port uut (
    .clk(clk), .rst_n(rst_n), .secure_mode(secure_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_tag(in_tag), .in_data(in_data),
    .out_req(out_req), .out_port(out_port), .out_grant(out_grant),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_data(out_data), .alert(alert)
  );

  // vector: dst_x(4) dst_y(4) rights(2) mode(2) pass(1) port(3)
  localparam logic [15:0] VEC [NV] = '{
    {4'd5, 4'd2, 2'b11, 2'b11, 1'b1, 3'd1},
    {4'd0, 4'd7, 2'b10, 2'b10, 1'b1, 3'd2},
    {4'd2, 4'd6, 2'b01, 2'b01, 1'b1, 3'd3},
    {4'd2, 4'd0, 2'b11, 2'b11, 1'b1, 3'd4},
    {4'd2, 4'd2, 2'b10, 2'b10, 1'b1, 3'd0},
    {4'd3, 4'd0, 2'b01, 2'b01, 1'b1, 3'd1},
    {4'd5, 4'd5, 2'b01, 2'b10, 1'b0, 3'd0},
    {4'd1, 4'd1, 2'b00, 2'b00, 1'b0, 3'd0},
    {4'd2, 4'd9, 2'b11, 2'b01, 1'b0, 3'd0}
  };

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [DW+1:0] rx [16];
  int            rx_n = 0;
  int            alert_n = 0;
  int            req_n = 0;
  int            port_bad = 0;
  logic [2:0]    req_port = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  // monitor and grant source, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && rx_n < 16) begin
        rx[rx_n] = {out_tag, out_data};
        rx_n++;
      end
      if (out_valid && out_port != req_port) port_bad++;
      if (out_req) begin
        req_port = out_port;
        if (!out_grant) req_n++;
      end
      if (alert) alert_n++;
    end
    out_grant <= out_req;
  end

  task automatic clear_mon();
    rx_n = 0; alert_n = 0; req_n = 0; port_bad = 0;
  endtask

  task automatic send_flit(input logic [1:0] t, input logic [DW-1:0] d);
    in_valid = 1'b1; in_tag = t; in_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [DW-1:0] mk_head(input logic [1:0] r,
      input logic [3:0] dx, input logic [3:0] dy);
    return {14'h0, r, 4'd2, 4'd2, dx, dy};
  endfunction

  task automatic send_pkt(input logic [DW-1:0] h, input int seed);
    send_flit(2'b01, h);
    send_flit(2'b10, 32'hB000_0000 + seed * 16 + 1);
    send_flit(2'b10, 32'hB000_0000 + seed * 16 + 2);
    send_flit(2'b11, 32'hB000_0000 + seed * 16 + 3);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    idle(2);
    // R1 reset state
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(!out_valid && !out_req && !alert, "R1 outputs idle",
          {out_valid, out_req, alert}, 0);
    rst_n = 1'b1;
    idle(2);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] h;
      logic          pass;
      h = mk_head(VEC[i][7:6], VEC[i][15:12], VEC[i][11:8]);
      pass = VEC[i][3];
      secure_mode = VEC[i][5:4];
      clear_mon();
      send_pkt(h, i);
      idle(8);
      check(rx_n == (pass ? 4 : 0), "R3 R4 flit count", rx_n, pass ? 4 : 0);
      check(alert_n == (pass ? 0 : 1), "R5 alert pulses", alert_n, pass ? 0 : 1);
      if (pass) begin
        check(req_port == VEC[i][2:0], "R6 route", req_port, VEC[i][2:0]);
        check(rx[0] == {2'b01, h} && rx[3] == {2'b11, 32'hB000_0000 + i * 16 + 3},
              "R4 flits unchanged", rx[0][DW-1:0], h);
        check(port_bad == 0, "R10 port held", port_bad, 0);
      end else begin
        check(req_n == 0, "R5 no request", req_n, 0);
      end
    end

    // R2 stray body/tail without head
    secure_mode = 2'b11;
    clear_mon();
    send_flit(2'b10, 32'h1111);
    send_flit(2'b11, 32'h2222);
    send_flit(2'b00, 32'h3333);
    idle(6);
    check(rx_n == 0 && alert_n == 0 && req_n == 0, "R2 stray discarded",
          rx_n + alert_n + req_n, 0);
    send_pkt(mk_head(2'b11, 4'd4, 4'd2), 20);
    idle(8);
    check(rx_n == 4, "R2 next packet intact", rx_n, 4);

    // R7 cut-through
    clear_mon();
    send_flit(2'b01, mk_head(2'b11, 4'd7, 4'd2));
    idle(4);
    check(rx_n == 1 && rx[0][DW+1:DW] == 2'b01, "R7 head leaves early", rx_n, 1);
    send_flit(2'b10, 32'h5);
    send_flit(2'b10, 32'h6);
    send_flit(2'b11, 32'h7);
    idle(6);
    check(rx_n == 4, "R7 packet complete", rx_n, 4);

    // R8 / R9 backpressure
    clear_mon();
    out_ready = 1'b0;
    send_pkt(mk_head(2'b11, 4'd2, 4'd5), 30);
    idle(2);
    check(in_ready == 1'b0, "R8 full backpressure", in_ready, 0);
    begin
      logic [DW-1:0] d0;
      d0 = out_data;
      check(out_valid == 1'b1, "R9 valid offered", out_valid, 1);
      idle(3);
      check(out_valid && out_data == d0, "R9 hold", out_data, d0);
    end
    out_ready = 1'b1;
    idle(8);
    check(rx_n == 4 && req_port == 3'd3, "R8 drain after release", rx_n, 4);

    // reject followed at once by a passing packet
    clear_mon();
    secure_mode = 2'b11;
    send_pkt(mk_head(2'b10, 4'd5, 4'd2), 40);
    send_pkt(mk_head(2'b11, 4'd0, 4'd2), 41);
    idle(10);
    check(alert_n == 1, "R5 single alert", alert_n, 1);
    check(rx_n == 4 && rx[0][DW-1:0] == mk_head(2'b11, 4'd0, 4'd2),
          "R4 follower forwarded", rx[0][DW-1:0], mk_head(2'b11, 4'd0, 4'd2));
    check(req_port == 3'd2, "R6 follower west", req_port, 2);

    finish_run();
  end
endmodule